// File: doc/BRIEF.md
# ID-Location Write Sequencer for a Two-Wire Programming Port

This block sits on the host side of a two-wire in-circuit programming link: one clock line that it drives, and one data line that it drives through an output enable. When it gets a start pulse, it captures an 8-byte identifier. It then plays a fixed script of thirteen transactions that writes those bytes into the target's ID area at 0x200000..0x200007. The block assumes the target is already in programming mode and that the area has been erased.

Each transaction carries a 4-bit command followed by a 16-bit word. Both fields are sent starting from bit 0. The data line changes together with the clock's rising edge and stays still while the clock is high, so the target samples it on the falling edge. The script runs in three parts:

- Eight core-instruction transactions select code memory, clear configuration access and load the three table-pointer bytes.
- Four buffer-write transactions carry the identifier.
- A final no-op transaction stretches one clock pulse to give the target its programming time.

The clock half-period and the two programming hold times are parameters, counted in system clock cycles.

Top module: `id_prog_seq`

## Requirements
- R1: After reset, and whenever reset is asserted, the outputs are `prog_clk_o`=0, `prog_dat_o`=0, `prog_dat_oe_o`=0, `busy_o`=0 and `done_o`=0.
- R2: A start pulse while idle raises `busy_o` and sends exactly 13 frames of 20 clock pulses each. A frame is a 4-bit command followed by a 16-bit word, each sent bit 0 first. The data line holds its value for the whole time the clock is high.
- R3: Frames 0..7 use command 4'b0000 with the words 16'h8EA6, 16'h9CA6, 16'h0E20, 16'h6EF8, 16'h0E00, 16'h6EF7, 16'h0E00 and 16'h6EF6, in that order. This order leaves the table pointer at 0x200000.
- R4: Frames 8, 9 and 10 use command 4'b1101, and frame 11 uses command 4'b1111. Frame 8+k carries the word {ID[2k+1], ID[2k]}, where ID[n] = `id_i[8n+7:8n]`.
- R5: Frame 12 is command 4'b0000 with the word 16'h0000. Its fourth command pulse is held high for HOLD_HI_CYC cycles and then low for HOLD_LO_CYC cycles.
- R6: Every other clock high phase, and every low phase inside a frame, lasts HALF_CYC cycles.
- R7: After the last pulse of frame 12, `done_o` is high for exactly one cycle. That cycle is the first cycle in which `busy_o` is low.
- R8: A start pulse while `busy_o` is high is ignored. The running script completes unchanged, using the identifier captured at the accepted start, and `done_o` pulses only once.
- R9: `prog_dat_oe_o` equals `busy_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| id_i | input | 64 | Identifier; byte n is bits 8n+7..8n |
| prog_clk_o | output | 1 | Programming clock to the target |
| prog_dat_o | output | 1 | Programming data value |
| prog_dat_oe_o | output | 1 | Data line drive enable |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start request that arrives while the script is part way through and carries a different identifier. The stimulus raises this request roughly a quarter of the way into a run and then decodes every transmitted bit. It passes only if all the frames still carry the first identifier and only one done pulse appears. The single stretched pulse in the final frame is also easy to miss. To catch it, the bench measures the length of every high and low phase, so any misplaced or wrongly sized hold shows up as a mismatch.

// File: rtl/idp_pkg.sv
package idp_pkg;
    localparam int CMD_W      = 4;
    localparam int WORD_W     = 16;
    localparam int FRAME_BITS = CMD_W + WORD_W;
    localparam int NUM_STEPS  = 13;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int HOLD_BIT   = CMD_W - 1;

    typedef enum logic [1:0] {PH_IDLE, PH_HI, PH_LO} phase_e;
    typedef enum logic {SQ_IDLE, SQ_RUN} seq_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [WORD_W-1:0] word;
        logic              hold;
    } frame_t;
endpackage

// File: rtl/idp_script.sv
module idp_script
    import idp_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [63:0]       id_i,
    output frame_t            frame_o
);
    localparam logic [CMD_W-1:0] C_CORE  = 4'b0000;
    localparam logic [CMD_W-1:0] C_WRINC = 4'b1101;
    localparam logic [CMD_W-1:0] C_WRGO  = 4'b1111;

    logic [1:0] pair;
    assign pair = step_i[1:0];

    always_comb begin
        frame_o = '{cmd: C_CORE, word: 16'h0000, hold: 1'b0};
        case (step_i)
            4'd0:  frame_o.word = 16'h8EA6;
            4'd1:  frame_o.word = 16'h9CA6;
            4'd2:  frame_o.word = 16'h0E20;
            4'd3:  frame_o.word = 16'h6EF8;
            4'd4:  frame_o.word = 16'h0E00;
            4'd5:  frame_o.word = 16'h6EF7;
            4'd6:  frame_o.word = 16'h0E00;
            4'd7:  frame_o.word = 16'h6EF6;
            4'd8, 4'd9, 4'd10, 4'd11: begin
                frame_o.cmd  = (step_i == 4'd11) ? C_WRGO : C_WRINC;
                frame_o.word = id_i[16*pair +: 16];
            end
            default: frame_o.hold = 1'b1;
        endcase
    end
endmodule

// File: rtl/idp_shifter.sv
module idp_shifter
    import idp_pkg::*;
#(
    parameter int HALF_CYC    = 250,
    parameter int HOLD_HI_CYC = 250000,
    parameter int HOLD_LO_CYC = 1250
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go_i,
    input  frame_t frame_i,
    output logic   pgc_o,
    output logic   pgd_o,
    output logic   fdone_o
);
    localparam int MAX_A = (HALF_CYC > HOLD_LO_CYC) ? HALF_CYC : HOLD_LO_CYC;
    localparam int MAX_C = (MAX_A > HOLD_HI_CYC) ? MAX_A : HOLD_HI_CYC;
    localparam int TW    = $clog2(MAX_C + 1);
    localparam logic [TW-1:0] T_HALF = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] T_HI   = TW'(HOLD_HI_CYC - 1);
    localparam logic [TW-1:0] T_LO   = TW'(HOLD_LO_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] HBIT     = BIT_W'(HOLD_BIT);

    typedef struct packed {
        phase_e                ph;
        logic [BIT_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sr;
        logic                  hold;
        logic [TW-1:0]         tmr;
        logic                  pgc;
        logic                  pgd;
        logic                  fdone;
    } sh_t;

    sh_t q, d;
    logic at_hold;
    assign at_hold = q.hold && (q.idx == HBIT);

    always_comb begin
        d       = q;
        d.fdone = 1'b0;
        case (q.ph)
            PH_IDLE: if (go_i) begin
                d.sr   = {frame_i.word, frame_i.cmd};
                d.hold = frame_i.hold;
                d.idx  = '0;
                d.ph   = PH_HI;
                d.pgc  = 1'b1;
                d.pgd  = frame_i.cmd[0];
                d.tmr  = T_HALF;
            end
            PH_HI: if (q.tmr == '0) begin
                d.ph  = PH_LO;
                d.pgc = 1'b0;
                d.tmr = at_hold ? T_LO : T_HALF;
            end else begin
                d.tmr = q.tmr - 1'b1;
            end
            PH_LO: if (q.tmr == '0) begin
                if (q.idx == LAST_BIT) begin
                    d.ph    = PH_IDLE;
                    d.pgd   = 1'b0;
                    d.fdone = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.sr  = q.sr >> 1;
                    d.ph  = PH_HI;
                    d.pgc = 1'b1;
                    d.pgd = q.sr[1];
                    d.tmr = (q.hold && (q.idx + 1'b1 == HBIT)) ? T_HI : T_HALF;
                end
            end else begin
                d.tmr = q.tmr - 1'b1;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, idx: '0, sr: '0, hold: 1'b0, tmr: '0,
                   pgc: 1'b0, pgd: 1'b0, fdone: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pgc_o   = q.pgc;
    assign pgd_o   = q.pgd;
    assign fdone_o = q.fdone;

    p_data_steady_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pgc && $past(q.pgc)) |-> $stable(q.pgd));
    p_bit_index_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= LAST_BIT);
    p_frame_end_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.fdone |=> !q.fdone);
    p_frame_ends_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.fdone |-> !q.pgc);
endmodule

// File: rtl/id_prog_seq.sv
module id_prog_seq
    import idp_pkg::*;
#(
    parameter int HALF_CYC    = 250,
    parameter int HOLD_HI_CYC = 250000,
    parameter int HOLD_LO_CYC = 1250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] id_i,
    output logic        prog_clk_o,
    output logic        prog_dat_o,
    output logic        prog_dat_oe_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        seq_e              st;
        logic [STEP_W-1:0] step;
        logic [63:0]       id;
        logic              go;
        logic              done;
    } top_t;

    top_t   q, d;
    frame_t frame;
    logic   fdone;

    idp_script i_script (
        .step_i  (q.step),
        .id_i    (q.id),
        .frame_o (frame)
    );

    idp_shifter #(
        .HALF_CYC    (HALF_CYC),
        .HOLD_HI_CYC (HOLD_HI_CYC),
        .HOLD_LO_CYC (HOLD_LO_CYC)
    ) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (q.go),
        .frame_i (frame),
        .pgc_o   (prog_clk_o),
        .pgd_o   (prog_dat_o),
        .fdone_o (fdone)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        case (q.st)
            SQ_IDLE: if (start_i) begin
                d.st   = SQ_RUN;
                d.step = '0;
                d.id   = id_i;
                d.go   = 1'b1;
            end
            SQ_RUN: if (fdone) begin
                if (q.step == LAST_STEP) begin
                    d.st   = SQ_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.step = q.step + 1'b1;
                    d.go   = 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, step: '0, id: '0, go: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o        = (q.st == SQ_RUN);
    assign prog_dat_oe_o = busy_o;
    assign done_o        = q.done;

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(q.step) == LAST_STEP);
    p_id_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(q.id));
    p_clock_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !prog_clk_o);
endmodule

// File: tb/test_id_prog_seq.sv
module test_id_prog_seq;
    localparam int HALF = 3;
    localparam int HHI  = 40;
    localparam int HLO  = 7;
    localparam int NBITS = 260;
    localparam int HOLD_IDX = 12 * 20 + 3;

    // {src, cmd, word}; src 0 = fixed word, 1..4 = identifier byte pair src-1
    localparam logic [22:0] VEC [0:12] = '{
        {3'd0, 4'h0, 16'h8EA6}, {3'd0, 4'h0, 16'h9CA6}, {3'd0, 4'h0, 16'h0E20},
        {3'd0, 4'h0, 16'h6EF8}, {3'd0, 4'h0, 16'h0E00}, {3'd0, 4'h0, 16'h6EF7},
        {3'd0, 4'h0, 16'h0E00}, {3'd0, 4'h0, 16'h6EF6}, {3'd1, 4'hD, 16'h0000},
        {3'd2, 4'hD, 16'h0000}, {3'd3, 4'hD, 16'h0000}, {3'd4, 4'hF, 16'h0000},
        {3'd0, 4'h0, 16'h0000}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] id_in = '0;
    logic pgc, pgd, pgd_oe, busy, done;

    int checks = 0, fails = 0, cyc = 0;
    logic prev_pgc = 1'b0;
    int run_len = 0, nbits = 0, done_cnt = 0, oe_bad = 0, done_busy_bad = 0;
    logic bitv [0:299];
    int   hi_len [0:299];
    int   lo_len [0:299];

    always #2 clk = ~clk;

    id_prog_seq #(.HALF_CYC(HALF), .HOLD_HI_CYC(HHI), .HOLD_LO_CYC(HLO)) i_id_prog_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .id_i(id_in),
        .prog_clk_o(pgc), .prog_dat_o(pgd), .prog_dat_oe_o(pgd_oe),
        .busy_o(busy), .done_o(done));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (pgc && !prev_pgc) begin
                if (nbits > 0 && nbits <= 300) lo_len[nbits-1] = run_len;
                run_len = 1;
            end else if (!pgc && prev_pgc) begin
                if (nbits < 300) begin
                    bitv[nbits] = pgd;
                    hi_len[nbits] = run_len;
                end
                nbits++;
                run_len = 1;
            end else begin
                run_len++;
            end
            prev_pgc = pgc;
            if (done) done_cnt++;
            if (done && busy) done_busy_bad++;
            if (busy != pgd_oe) oe_bad++;
        end
    end

    task automatic clear_mon();
        nbits = 0; run_len = 0; done_cnt = 0; oe_bad = 0; done_busy_bad = 0;
        prev_pgc = pgc;
    endtask

    task automatic pulse_start(input logic [63:0] v);
        @(negedge clk);
        id_in = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_and_check(input logic [63:0] v, input bit inject, input string tag);
        logic [15:0] w_exp, w_act;
        logic [3:0]  c_exp, c_act;
        int bad_hi, bad_lo;
        clear_mon();
        pulse_start(v);
        check(busy == 1'b1, {"R2 busy after start ", tag}, 32'(busy), 1);
        if (inject) begin
            repeat (300) @(negedge clk);
            id_in = ~v; start = 1'b1;  // R8: start while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && cyc < 150000) @(negedge clk);
        repeat (20) @(negedge clk);
        check(nbits == NBITS, {"R2 pulse count ", tag}, 32'(nbits), NBITS);
        for (int f = 0; f < 13; f++) begin
            c_exp = VEC[f][19:16];
            w_exp = (VEC[f][22:20] == 0) ? VEC[f][15:0]
                                          : v[16*(int'(VEC[f][22:20])-1) +: 16];
            for (int b = 0; b < 4; b++) c_act[b] = bitv[f*20+b];
            for (int b = 0; b < 16; b++) w_act[b] = bitv[f*20+4+b];
            check({c_act, w_act} == {c_exp, w_exp},
                  (f < 8) ? {"R3 setup frame ", tag} : (f < 12) ? {"R4 id frame ", tag}
                                                     : {"R5 final frame ", tag},
                  {12'h0, c_act, w_act}, {12'h0, c_exp, w_exp});
        end
        bad_hi = 0; bad_lo = 0;
        for (int k = 0; k < NBITS; k++) begin
            if (k != HOLD_IDX && hi_len[k] != HALF) bad_hi++;
            if (k != HOLD_IDX && (k % 20) != 19 && lo_len[k] != HALF) bad_lo++;
        end
        check(bad_hi == 0, {"R6 high phase lengths ", tag}, 32'(bad_hi), 0);
        check(bad_lo == 0, {"R6 low phase lengths ", tag}, 32'(bad_lo), 0);
        check(hi_len[HOLD_IDX] == HHI, {"R5 hold high ", tag}, 32'(hi_len[HOLD_IDX]), HHI);
        check(lo_len[HOLD_IDX] == HLO, {"R5 hold low ", tag}, 32'(lo_len[HOLD_IDX]), HLO);
        check(done_cnt == 1, {"R7 done pulse count ", tag}, 32'(done_cnt), 1);
        check(done_busy_bad == 0, {"R7 done while busy ", tag}, 32'(done_busy_bad), 0);
        check(oe_bad == 0, {"R9 oe follows busy ", tag}, 32'(oe_bad), 0);
        check(busy == 1'b0 && pgc == 1'b0, {"R8 idle after run ", tag},
              {30'h0, busy, pgc}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check({pgc, pgd, pgd_oe, busy, done} == 5'b0, "R1 reset outputs",
              {27'h0, pgc, pgd, pgd_oe, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({pgc, pgd, pgd_oe, busy, done} == 5'b0, "R1 idle after reset",
              {27'h0, pgc, pgd, pgd_oe, busy, done}, 0);

        run_and_check(64'h0123_4567_89AB_CDEF, 1'b0, "runA");
        run_and_check(64'hF0E1_D2C3_B4A5_9687, 1'b1, "runB_R8");
        run_and_check(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "runC");

        // R1: reset in the middle of a run
        pulse_start(64'h5555_AAAA_5555_AAAA);
        repeat (137) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({pgc, pgd, pgd_oe, busy, done} == 5'b0, "R1 reset mid-run",
              {27'h0, pgc, pgd, pgd_oe, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_and_check(64'h0000_0000_0000_0000, 1'b0, "runD");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule